// File: doc/BRIEF.md
# Address-Multiplexing DRAM Controller with Row Refresh

This block sits between a simple host request port and an asynchronous DRAM of 4M words by 4 bits, internally built from four 2048 x 2048 cell arrays that are always read or written together. The DRAM exposes only 11 address pins, half the width of a word address, so every access is made in two phases. The upper half of the 22-bit host address goes out first and is captured by the falling row strobe. The lower half follows on the same pins and is captured by the falling column strobe.

A write drives the write strobe and the data pins during the column phase. A read drives the output-enable strobe instead and samples the data pins at the end of that phase. Every access ends with a precharge gap in which all strobes are high. Cell charge leaks, so an interval timer raises a refresh request at a fixed period. The controller then runs a row-strobe-only cycle on the row named by an internal counter, which rewrites that row in place, and advances the counter. A pending refresh takes precedence over a waiting host request, but never cuts short an access that has already begun.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is held, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high (inactive), `rsp_valid` and `dram_dq_oe` are 0, and `req_ready` is 1.
- R2: While the row strobe is low and the column strobe high, the address pins carry host address bits [21:11]. While the column strobe is low, they carry bits [10:0] and do not change.
- R3: The column strobe falls only after the row strobe has been low for exactly `T_RCD` cycles. It stays low for exactly `T_CAS` cycles with the row strobe still low. After the row strobe rises, it stays high for at least `T_RP` cycles.
- R4: In a write, `dram_we_n` is 0, `dram_oe_n` is 1 and `dram_dq_oe` is 1 with the host write data on `dram_dq_out`, all only during the column phase. In a read, `dram_oe_n` is 0, `dram_we_n` is 1 and `dram_dq_oe` is 0. The two strobes are never both low.
- R5: A refresh is a cycle with the row strobe low for `T_RCD`+`T_CAS` cycles and the column strobe high, with the refresh counter on the address pins. Successive refreshes use rows 0, 1, 2, ... and the counter wraps from 2047 to 0.
- R6: Each read yields exactly one `rsp_valid` pulse, one cycle wide, in the cycle after the column phase ends. `rsp_rdata` then holds the 4-bit word most recently written to that address. Writes produce no pulse.
- R7: While a refresh is pending, `req_ready` is 0, so a refresh and a waiting host request are resolved in favour of the refresh. An access already in progress completes. Refresh starts are never more than `REF_INTERVAL`+`T_RCD`+`T_CAS`+`T_RP`+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: [21:11] row, [10:0] column |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 4 | Read data |
| dram_addr | output | 11 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
The refresh timer and a host request can want the bus in the same cycle. The timer can also fire in the middle of an access. The bench keeps the request port almost constantly busy with short idle gaps of varying length, so over more than two thousand refresh periods both cases occur many times. A DRAM model at the pins classifies each row-strobe cycle as an access or a refresh. It checks that column phases are never shortened and that refresh rows keep counting without a skip. Each time a refresh starts while the host request is still held waiting, it counts a deferral. The run must record at least one deferral, and every deferred request must still complete later with the correct read data.

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 11,
  parameter int DATA_W       = 4,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 780
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CNT_W = $clog2(T_RCD + T_CAS + T_RP + 1) + 1;
  localparam int TMR_W = $clog2(REF_INTERVAL + 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_PRE, S_REF} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic               wr_q;
  logic [DATA_W-1:0]  wd_q;
  logic [ROW_W-1:0]   ref_row;
  logic               ref_pend;
  logic [TMR_W-1:0]   tmr;
  logic               tmr_fire;
  logic               cnt_done;

  assign tmr_fire = (tmr == TMR_W'(REF_INTERVAL - 1));
  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      ref_row   <= '0;
      ref_pend  <= 1'b0;
      tmr       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      tmr       <= tmr_fire ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            st       <= S_REF;
            cnt      <= CNT_W'(T_RCD + T_CAS - 1);
            ref_pend <= 1'b0;
          end else if (req_valid) begin
            st    <= S_ROW;
            cnt   <= CNT_W'(T_RCD - 1);
            row_q <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q <= req_addr[COL_W-1:0];
            wr_q  <= req_write;
            wd_q  <= req_wdata;
          end
        end
        S_ROW: begin
          if (cnt_done) begin
            st  <= S_COL;
            cnt <= CNT_W'(T_CAS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_COL: begin
          if (cnt_done) begin
            if (!wr_q) begin
              rsp_rdata <= dram_dq_in;
              rsp_valid <= 1'b1;
            end
            st  <= S_PRE;
            cnt <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_REF: begin
          if (cnt_done) begin
            ref_row <= ref_row + 1'b1;
            st      <= S_PRE;
            cnt     <= CNT_W'(T_RP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PRE: begin
          if (cnt_done) st <= S_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      if (tmr_fire) ref_pend <= 1'b1;
    end
  end

  assign req_ready   = (st == S_IDLE) && !ref_pend;
  assign dram_ras_n  = !((st == S_ROW) || (st == S_COL) || (st == S_REF));
  assign dram_cas_n  = (st != S_COL);
  assign dram_we_n   = !((st == S_COL) && wr_q);
  assign dram_oe_n   = !((st == S_COL) && !wr_q);
  assign dram_dq_oe  = (st == S_COL) && wr_q;
  assign dram_dq_out = wd_q;
  assign dram_addr   = (st == S_COL) ? PIN_W'(col_q) :
                       (st == S_REF) ? PIN_W'(ref_row) : PIN_W'(row_q);
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int ROW_W = 11,
  parameter int PIN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [PIN_W-1:0] addr,
  input logic             rsp_valid,
  input logic             req_ready,
  input logic             ref_pend,
  input logic [ROW_W-1:0] ref_row
);
  a_r3_cas_behind_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (!ras_n && $past(!ras_n)));

  a_r3_ras_under_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  a_r4_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !oe_n) |-> !cas_n);

  a_r2_col_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(addr));

  a_r6_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_ref_blocks_host: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);

  a_r5_row_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_row != $past(ref_row)) |-> (ref_row == ROW_W'($past(ref_row) + 1'b1)));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.ROW_W(ROW_W), .PIN_W(PIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .we_n      (dram_we_n),
  .oe_n      (dram_oe_n),
  .addr      (dram_addr),
  .rsp_valid (rsp_valid),
  .req_ready (req_ready),
  .ref_pend  (ref_pend),
  .ref_row   (ref_row)
);

// File: tb/dram_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_mux_ctrl_tb_top;
  localparam int T_RCD = 3;
  localparam int T_CAS = 2;
  localparam int T_RP  = 2;
  localparam int RI    = 24;
  localparam int NROWS = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [3:0]  dram_dq_out;
  logic        dram_dq_oe;
  logic [3:0]  dq_in_r = '0;

  always #4 clk = ~clk;

  dram_mux_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(RI)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dq_in_r)
  );

  typedef struct { bit wr; logic [21:0] a; logic [3:0] d; } op_t;
  op_t        opq[$];
  logic [3:0] rdq[$];
  logic [3:0] shadow[int];
  logic [3:0] cells[int];

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [21:0] a, input logic [3:0] d);
    op_t o;
    o.wr = wr; o.a = a; o.d = d;
    opq.push_back(o);
    if (wr) shadow[int'(a)] = d;
    else    rdq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // pin-level DRAM model and protocol monitor
  bit ras_q = 1, cas_q = 1, cas_seen = 0, fall_req = 0, wrapped = 0;
  int run = 0, cas_run = 0, hi_run = 1000, cyc = 0, start_cyc = 0, last_ref = -1;
  int exp_ref = 0, ref_cnt = 0, deferred = 0;
  logic [10:0] row_l = '0;
  op_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!dram_ras_n) begin
        if (ras_q) begin
          chk(hi_run >= T_RP, "R3", "precharge gap", hi_run, T_RP);
          row_l = dram_addr; run = 1; cas_seen = 0; start_cyc = cyc;
          fall_req = req_valid;
        end else run++;
        if (dram_cas_n && !cas_seen)
          chk(dram_addr == row_l, "R2", "row held on pins", dram_addr, row_l);
      end
      if (!dram_cas_n) begin
        if (cas_q) begin
          chk(run == T_RCD + 1, "R3", "row-to-column delay", run - 1, T_RCD);
          if (opq.size() == 0) begin
            chk(0, "R2", "unexpected access", 0, 1);
            cur.wr = 0; cur.a = '0; cur.d = '0;
          end else begin
            cur = opq.pop_front();
            chk({row_l, dram_addr} == cur.a, "R2", "row/column split",
                {row_l, dram_addr}, cur.a);
          end
          chk(dram_we_n == !cur.wr && dram_oe_n == cur.wr, "R4", "we/oe strobes",
              {dram_we_n, dram_oe_n}, {!cur.wr, cur.wr});
          cas_seen = 1; cas_run = 1;
        end else cas_run++;
        if (cur.wr) begin
          chk(dram_dq_oe && dram_dq_out == cur.d, "R4", "write data on pins",
              {dram_dq_oe, dram_dq_out}, {1'b1, cur.d});
          cells[int'({row_l, dram_addr})] = dram_dq_out;
        end else begin
          chk(!dram_dq_oe, "R4", "no drive on read", dram_dq_oe, 0);
          dq_in_r = cells.exists(int'({row_l, dram_addr})) ?
                    cells[int'({row_l, dram_addr})] : 4'h0;
        end
      end else if (!cas_q) begin
        chk(cas_run == T_CAS, "R3", "column strobe width", cas_run, T_CAS);
      end
      if (dram_ras_n && !ras_q) begin
        if (!cas_seen) begin
          chk(run == T_RCD + T_CAS, "R5", "refresh strobe width", run, T_RCD + T_CAS);
          chk(row_l == 11'(exp_ref), "R5", "refresh row", row_l, exp_ref);
          if (row_l == 11'(NROWS - 1)) wrapped = 1;
          exp_ref = (exp_ref + 1) % NROWS;
          ref_cnt++;
          if (last_ref >= 0)
            chk(start_cyc - last_ref <= RI + T_RCD + T_CAS + T_RP + 2, "R7",
                "refresh spacing", start_cyc - last_ref, RI + T_RCD + T_CAS + T_RP + 2);
          last_ref = start_cyc;
          if (fall_req) deferred++;
        end
        hi_run = 1;
      end else if (dram_ras_n) hi_run++;
      ras_q = dram_ras_n; cas_q = dram_cas_n;
    end
  end

  // response monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (rdq.size() == 0) chk(0, "R6", "response without read", 1, 0);
      else begin
        logic [3:0] e;
        e = rdq.pop_front();
        chk(rsp_rdata == e, "R6", "read data", rsp_rdata, e);
      end
    end
  end

  logic [21:0] hist[16];
  logic [21:0] lfsr = 22'h2A5C31;

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
      chk(!rsp_valid && !dram_dq_oe && req_ready, "R1", "handshake in reset",
          {rsp_valid, dram_dq_oe, req_ready}, 3'b001);
    end
    rst_n = 1'b1;
    issue(1, 22'h000000, 4'h5);
    issue(1, 22'h3FFFFF, 4'hA);
    issue(1, 22'h3FF800, 4'h3);
    issue(1, 22'h0007FF, 4'hC);
    issue(0, 22'h3FFFFF, 4'h0);
    issue(0, 22'h000000, 4'h0);
    issue(0, 22'h0007FF, 4'h0);
    issue(0, 22'h3FF800, 4'h0);
    issue(1, 22'h000000, 4'hF);
    issue(0, 22'h000000, 4'h0);
    for (int k = 0; k < 16; k++) hist[k] = (k % 2 == 0) ? 22'h3FFFFF : 22'h0007FF;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[20:0], lfsr[21] ^ lfsr[20]};
      if (i % 3 == 2) issue(0, hist[(i * 7) % 16], 4'h0);
      else begin
        issue(1, lfsr, lfsr[3:0] ^ 4'(i));
        hist[i % 16] = lfsr;
      end
      if (lfsr[5:4] == 2'b00) repeat (int'(lfsr[8:6])) @(negedge clk);
    end
    while (ref_cnt < NROWS + 2) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(wrapped, "R5", "counter wrapped past last row", wrapped, 1);
    chk(exp_ref != 0 || ref_cnt % NROWS == 0, "R5", "refresh count consistent", exp_ref, ref_cnt % NROWS);
    chk(deferred > 0, "R7", "refresh beat waiting host", deferred, 1);
    chk(opq.size() == 0, "R2", "all accesses seen", opq.size(), 0);
    chk(rdq.size() == 0, "R6", "all reads answered", rdq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule